// File: doc/BRIEF.md
# Trap Entry Sequencer

This block performs the state changes a register-windowed 64-bit processor makes when it takes a trap. A one-cycle strobe presents a 9-bit trap type together with the architectural state that is live at that moment. In the same clock edge the block advances its trap level and records the pre-trap context in a trap-stack slot chosen by the new level. It also produces the updated processor-state word, window pointer and global level, plus the new PC and NPC derived from the trap base address.

The block owns the trap-level register, the error-state flag and the trap stack. The updated state values appear on registered outputs that the surrounding core loads back into its own registers. The core can read any trap-stack slot through a registered read port with one cycle of latency. If a trap arrives while the level is already at its ceiling, the block rejects it, leaves every output and the stack as they were, and latches the error-state flag until reset.

Top module: `trap_entry_unit`

## Requirements
- R1: During and after synchronous reset, `tl_out` is 0, and `error_state`, `trap_taken`, `pstate_out`, `cwp_out`, `gl_out`, `pc_out` and `npc_out` are all 0.
- R2: A strobe with `tl_out` below MAX_TL-1 raises `tl_out` by one on the next edge, pulses `trap_taken` for one cycle and does not set the RED bit (bit 5) in `pstate_out`.
- R3: A strobe with `tl_out` equal to MAX_TL-1 raises `tl_out` to MAX_TL and sets RED (bit 5) in both `pstate_out` and the saved processor-state field.
- R4: A strobe with `tl_out` equal to MAX_TL takes no trap. `trap_taken` stays low, `error_state` rises and stays high until reset, and `tl_out`, `pstate_out`, `pc_out` and every trap-stack slot are left unchanged.
- R5: The saved state word is 43 bits wide. CWP sits in its low bits and the processor state ANDed with 0xF3F (after any RED setting) occupies 19:8. ASI occupies 31:24 and CCR occupies 39:32. Unused bits are zero.
- R6: With GL_EN set, the incoming 3-bit GL is stored in bits 42:40 of the saved word, and `gl_out` is GL+1 modulo 8.
- R7: The stack slot indexed by the new trap level receives the saved word, PC, NPC and trap type. A slot address placed on `rd_level` appears on the `rd_*` outputs one edge later.
- R8: Trap type 0x060 (interrupt vector) yields a `pstate_out` with the interrupt-globals bit (11) set and the MMU-globals (10) and alternate-globals (0) bits cleared. FPU-enable (4) and privileged (2) are set, and all other bits are taken from the input.
- R9: Trap types 0x008, 0x030 and 0x064 through 0x06F select the MMU-globals bit (10) in the same manner as R8.
- R10: Every other trap type selects the alternate-globals bit (0) in the same manner as R8.
- R11: Trap type 0x024 (clean window) sets `cwp_out` to CWP-1 modulo NWIN.
- R12: When the type ANDed with 0x1C0 equals 0x080 (spill), `cwp_out` is CWP-CANSAVE-2 modulo NWIN. When it equals 0x0C0 (fill), `cwp_out` is CWP+1 modulo NWIN. All other types leave CWP unchanged.
- R13: `pc_out` is the trap base with bits 14:0 cleared, ORed with bit 14 when the new level exceeds 1 and with the trap type shifted left by 5. `npc_out` is `pc_out`+4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trap_valid | input | 1 | One-cycle trap request strobe |
| trap_type | input | 9 | Trap type code |
| ccr_in | input | 8 | Current condition codes |
| asi_in | input | 8 | Current address space identifier |
| pstate_in | input | 12 | Current processor-state word |
| cwp_in | input | CW | Current window pointer |
| cansave_in | input | CW | Current count of saveable windows |
| gl_in | input | 3 | Current global level |
| pc_in | input | VA_W | PC of the trapping point |
| npc_in | input | VA_W | NPC of the trapping point |
| tba_in | input | VA_W | Trap base address |
| rd_level | input | LW | Trap-stack slot to read |
| tl_out | output | LW | Current trap level |
| pstate_out | output | 12 | Processor-state word after the trap |
| cwp_out | output | CW | Window pointer after the trap |
| gl_out | output | 3 | Global level after the trap |
| pc_out | output | VA_W | Trap vector PC |
| npc_out | output | VA_W | Trap vector NPC |
| trap_taken | output | 1 | Pulses for one cycle after an accepted trap |
| error_state | output | 1 | Sticky flag for a trap rejected at the level ceiling |
| rd_tstate | output | 43 | Saved state word of the read slot |
| rd_tpc | output | VA_W | Saved PC of the read slot |
| rd_tnpc | output | VA_W | Saved NPC of the read slot |
| rd_tt | output | 9 | Saved trap type of the read slot |

## Verification
The bench builds the block with MAX_TL=4 and NWIN=6. The low ceiling lets the full climb to RED and the rejected trap after it be reached in a handful of strobes. The six-window configuration makes the modulo wrap of the window pointer a genuine non-power-of-two case, not a natural counter overflow. With this configuration, every one of the 512 trap types can be fired from level 0 in a short run, each with its own CWP, CANSAVE, GL and state pattern, so every class decode, window adjustment and vector computation is compared against an arithmetic model.

// File: rtl/trap_entry_pkg.sv
package trap_entry_pkg;

  localparam int TT_W     = 9;
  localparam int PS_W     = 12;
  localparam int TSTATE_W = 43;
  localparam int GL_W     = 3;

  // processor-state bit positions
  localparam int PS_AG   = 0;
  localparam int PS_PRIV = 2;
  localparam int PS_PEF  = 4;
  localparam int PS_RED  = 5;
  localparam int PS_MG   = 10;
  localparam int PS_IG   = 11;

  localparam logic [PS_W-1:0] PS_SAVE_MASK = 12'hF3F;

  // trap type codes the unit decodes
  localparam logic [TT_W-1:0] TT_INT_VEC    = 9'h060;
  localparam logic [TT_W-1:0] TT_IACC_FLT   = 9'h008;
  localparam logic [TT_W-1:0] TT_DACC_FLT   = 9'h030;
  localparam logic [TT_W-1:0] TT_MMU_LO     = 9'h064;
  localparam logic [TT_W-1:0] TT_MMU_HI     = 9'h06F;
  localparam logic [TT_W-1:0] TT_CLEAN_WIN  = 9'h024;
  localparam logic [TT_W-1:0] TT_GROUP_MASK = 9'h1C0;
  localparam logic [TT_W-1:0] TT_SPILL_GRP  = 9'h080;
  localparam logic [TT_W-1:0] TT_FILL_GRP   = 9'h0C0;

  typedef enum logic [1:0] {GSEL_ALT, GSEL_MMU, GSEL_INT} gsel_e;
  typedef enum logic [1:0] {WADJ_NONE, WADJ_CLEAN, WADJ_SPILL, WADJ_FILL} wadj_e;

endpackage

// File: rtl/trap_level_ctl.sv
module trap_level_ctl #(
  parameter int MAX_TL = 6,
  parameter int LW     = $clog2(MAX_TL + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          trap_valid,
  output logic [LW-1:0] tl_q,
  output logic [LW-1:0] tl_next,
  output logic          accept,
  output logic          enter_red,
  output logic          err_q
);
  localparam logic [LW-1:0] TL_MAX    = LW'(MAX_TL);
  localparam logic [LW-1:0] TL_PENULT = LW'(MAX_TL - 1);

  always_comb begin
    accept    = trap_valid && (tl_q < TL_MAX);
    enter_red = accept && (tl_q == TL_PENULT);
    tl_next   = tl_q + LW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tl_q  <= '0;
      err_q <= 1'b0;
    end else begin
      if (accept) tl_q <= tl_next;
      if (trap_valid && !accept) err_q <= 1'b1;
    end
  end

  // R2 / R3: an accepted trap raises the level by exactly one
  a_r2_level_step: assert property (@(posedge clk) disable iff (rst)
    (trap_valid && tl_q < TL_MAX) |=> (tl_q == $past(tl_q) + LW'(1)));

  // R4: a trap at the ceiling freezes the level and raises the error flag
  a_r4_ceiling_reject: assert property (@(posedge clk) disable iff (rst)
    (trap_valid && tl_q >= TL_MAX) |=> (err_q && tl_q == $past(tl_q)));

  // R4: the error flag never drops outside reset
  a_r4_error_sticky: assert property (@(posedge clk) disable iff (rst)
    err_q |=> err_q);

endmodule

// File: rtl/trap_pstate_sel.sv
module trap_pstate_sel
  import trap_entry_pkg::*;
(
  input  logic [TT_W-1:0] tt,
  input  logic [PS_W-1:0] pstate_in,
  input  logic            enter_red,
  output logic [PS_W-1:0] pstate_next,
  output logic [PS_W-1:0] pstate_saved
);
  gsel_e           gsel;
  logic [PS_W-1:0] with_red;

  always_comb begin
    if (tt == TT_INT_VEC)
      gsel = GSEL_INT;
    else if (tt == TT_IACC_FLT || tt == TT_DACC_FLT ||
             (tt >= TT_MMU_LO && tt <= TT_MMU_HI))
      gsel = GSEL_MMU;
    else
      gsel = GSEL_ALT;

    with_red = pstate_in;
    if (enter_red) with_red[PS_RED] = 1'b1;

    pstate_saved = with_red & PS_SAVE_MASK;

    pstate_next          = with_red;
    pstate_next[PS_AG]   = (gsel == GSEL_ALT);
    pstate_next[PS_MG]   = (gsel == GSEL_MMU);
    pstate_next[PS_IG]   = (gsel == GSEL_INT);
    pstate_next[PS_PEF]  = 1'b1;
    pstate_next[PS_PRIV] = 1'b1;
  end

endmodule

// File: rtl/trap_cwp_adj.sv
module trap_cwp_adj
  import trap_entry_pkg::*;
#(
  parameter int NWIN = 8,
  parameter int CW   = $clog2(NWIN)
) (
  input  logic [TT_W-1:0] tt,
  input  logic [CW-1:0]   cwp_in,
  input  logic [CW-1:0]   cansave_in,
  output logic [CW-1:0]   cwp_next
);
  wadj_e       kind;
  int unsigned sum;

  always_comb begin
    if (tt == TT_CLEAN_WIN)
      kind = WADJ_CLEAN;
    else if ((tt & TT_GROUP_MASK) == TT_SPILL_GRP)
      kind = WADJ_SPILL;
    else if ((tt & TT_GROUP_MASK) == TT_FILL_GRP)
      kind = WADJ_FILL;
    else
      kind = WADJ_NONE;

    // offsets of whole NWIN multiples keep the sum non-negative
    case (kind)
      WADJ_CLEAN: sum = int'(cwp_in) + NWIN - 1;
      WADJ_SPILL: sum = int'(cwp_in) + 2 * NWIN - int'(cansave_in) - 2;
      WADJ_FILL:  sum = int'(cwp_in) + 1;
      default:    sum = int'(cwp_in);
    endcase
    cwp_next = CW'(sum % NWIN);
  end

endmodule

// File: rtl/trap_stack_ram.sv
module trap_stack_ram #(
  parameter int AW = 3,
  parameter int DW = 180
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 2 ** AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
  import trap_entry_pkg::*;
#(
  parameter int MAX_TL = 6,
  parameter int NWIN   = 8,
  parameter int VA_W   = 64,
  parameter bit GL_EN  = 1'b1,
  parameter int LW     = $clog2(MAX_TL + 1),
  parameter int CW     = $clog2(NWIN)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                trap_valid,
  input  logic [TT_W-1:0]     trap_type,
  input  logic [7:0]          ccr_in,
  input  logic [7:0]          asi_in,
  input  logic [PS_W-1:0]     pstate_in,
  input  logic [CW-1:0]       cwp_in,
  input  logic [CW-1:0]       cansave_in,
  input  logic [GL_W-1:0]     gl_in,
  input  logic [VA_W-1:0]     pc_in,
  input  logic [VA_W-1:0]     npc_in,
  input  logic [VA_W-1:0]     tba_in,
  input  logic [LW-1:0]       rd_level,
  output logic [LW-1:0]       tl_out,
  output logic [PS_W-1:0]     pstate_out,
  output logic [CW-1:0]       cwp_out,
  output logic [GL_W-1:0]     gl_out,
  output logic [VA_W-1:0]     pc_out,
  output logic [VA_W-1:0]     npc_out,
  output logic                trap_taken,
  output logic                error_state,
  output logic [TSTATE_W-1:0] rd_tstate,
  output logic [VA_W-1:0]     rd_tpc,
  output logic [VA_W-1:0]     rd_tnpc,
  output logic [TT_W-1:0]     rd_tt
);
  localparam int ENTRY_W = TT_W + 2 * VA_W + TSTATE_W;
  localparam logic [VA_W-1:0] BASE_CLR = VA_W'(32'h7FFF);
  localparam logic [VA_W-1:0] TL_OFS   = VA_W'(32'h4000);

  logic [LW-1:0]       tl_next;
  logic                accept, enter_red;
  logic [PS_W-1:0]     pstate_next, pstate_saved;
  logic [CW-1:0]       cwp_next;
  logic [TSTATE_W-1:0] tstate_word;
  logic [VA_W-1:0]     pc_next;
  logic [ENTRY_W-1:0]  wr_entry, rd_entry;

  trap_level_ctl #(.MAX_TL(MAX_TL), .LW(LW)) u_level (
    .clk(clk), .rst(rst), .trap_valid(trap_valid),
    .tl_q(tl_out), .tl_next(tl_next), .accept(accept),
    .enter_red(enter_red), .err_q(error_state)
  );

  trap_pstate_sel u_pstate (
    .tt(trap_type), .pstate_in(pstate_in), .enter_red(enter_red),
    .pstate_next(pstate_next), .pstate_saved(pstate_saved)
  );

  trap_cwp_adj #(.NWIN(NWIN), .CW(CW)) u_cwp (
    .tt(trap_type), .cwp_in(cwp_in), .cansave_in(cansave_in),
    .cwp_next(cwp_next)
  );

  always_comb begin
    tstate_word        = '0;
    tstate_word[39:32] = ccr_in;
    tstate_word[31:24] = asi_in;
    tstate_word[19:8]  = pstate_saved;
    tstate_word[CW-1:0] = cwp_in;
    if (GL_EN) tstate_word[42:40] = gl_in;

    pc_next = (tba_in & ~BASE_CLR)
            | ((tl_next > LW'(1)) ? TL_OFS : '0)
            | (VA_W'(trap_type) << 5);

    wr_entry = {trap_type, npc_in, pc_in, tstate_word};
  end

  trap_stack_ram #(.AW(LW), .DW(ENTRY_W)) u_stack (
    .clk(clk), .we(accept), .waddr(tl_next), .wdata(wr_entry),
    .raddr(rd_level), .rdata(rd_entry)
  );

  assign {rd_tt, rd_tnpc, rd_tpc, rd_tstate} = rd_entry;

  always_ff @(posedge clk) begin
    if (rst) begin
      pstate_out <= '0;
      cwp_out    <= '0;
      gl_out     <= '0;
      pc_out     <= '0;
      npc_out    <= '0;
      trap_taken <= 1'b0;
    end else begin
      trap_taken <= accept;
      if (accept) begin
        pstate_out <= pstate_next;
        cwp_out    <= cwp_next;
        gl_out     <= GL_EN ? gl_in + GL_W'(1) : gl_in;
        pc_out     <= pc_next;
        npc_out    <= pc_next + VA_W'(4);
      end
    end
  end

  // R8 / R9 / R10: exactly one globals select, privileged and FPU enabled
  a_r10_pstate_class: assert property (@(posedge clk) disable iff (rst)
    trap_taken |-> (pstate_out[PS_PRIV] && pstate_out[PS_PEF] &&
      $countones({pstate_out[PS_IG], pstate_out[PS_MG], pstate_out[PS_AG]}) == 1));

  // R3: reaching the ceiling level always carries RED
  a_r3_red_at_ceiling: assert property (@(posedge clk) disable iff (rst)
    (trap_taken && tl_out == LW'(MAX_TL)) |-> pstate_out[PS_RED]);

  // R13: vector offset bit follows the level, low bits stay clear
  a_r13_vector_shape: assert property (@(posedge clk) disable iff (rst)
    trap_taken |-> (pc_out[14] == (tl_out > LW'(1)) && pc_out[4:0] == 5'd0));

  // R11 / R12: window pointer stays inside the window file
  a_r12_cwp_range: assert property (@(posedge clk) disable iff (rst)
    trap_taken |-> (int'(cwp_out) < NWIN));

  // R4: a rejected trap leaves the vector untouched
  a_r4_hold_vector: assert property (@(posedge clk) disable iff (rst)
    (trap_valid && !accept) |=> (!trap_taken && $stable(pc_out) && $stable(pstate_out)));

endmodule

// File: tb/trap_entry_unit_bench.sv
module trap_entry_unit_bench;
  localparam int MAX_TL = 4;
  localparam int NWIN   = 6;
  localparam int LW     = 3;
  localparam int CW     = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic trap_valid = 1'b0;
  logic [8:0]  trap_type = '0;
  logic [7:0]  ccr_in = '0, asi_in = '0;
  logic [11:0] pstate_in = '0;
  logic [CW-1:0] cwp_in = '0, cansave_in = '0;
  logic [2:0]  gl_in = '0;
  logic [63:0] pc_in = '0, npc_in = '0, tba_in = '0;
  logic [LW-1:0] rd_level = '0;
  logic [LW-1:0] tl_out;
  logic [11:0] pstate_out;
  logic [CW-1:0] cwp_out;
  logic [2:0]  gl_out;
  logic [63:0] pc_out, npc_out;
  logic trap_taken, error_state;
  logic [42:0] rd_tstate;
  logic [63:0] rd_tpc, rd_tnpc;
  logic [8:0]  rd_tt;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  trap_entry_unit #(.MAX_TL(MAX_TL), .NWIN(NWIN)) u_trap_entry_unit (
    .clk(clk), .rst(rst), .trap_valid(trap_valid), .trap_type(trap_type),
    .ccr_in(ccr_in), .asi_in(asi_in), .pstate_in(pstate_in), .cwp_in(cwp_in),
    .cansave_in(cansave_in), .gl_in(gl_in), .pc_in(pc_in), .npc_in(npc_in),
    .tba_in(tba_in), .rd_level(rd_level), .tl_out(tl_out),
    .pstate_out(pstate_out), .cwp_out(cwp_out), .gl_out(gl_out),
    .pc_out(pc_out), .npc_out(npc_out), .trap_taken(trap_taken),
    .error_state(error_state), .rd_tstate(rd_tstate), .rd_tpc(rd_tpc),
    .rd_tnpc(rd_tnpc), .rd_tt(rd_tt)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] m_pstate(input int tt, input logic [11:0] p, input bit red);
    logic [11:0] r;
    r = p & ~12'hC01;
    r = r | 12'h014;
    if (red) r = r | 12'h020;
    if (tt == 'h060) r = r | 12'h800;
    else if (tt == 'h008 || tt == 'h030 || (tt >= 'h064 && tt <= 'h06F)) r = r | 12'h400;
    else r = r | 12'h001;
    return r;
  endfunction

  function automatic int m_cwp(input int tt, input int cwp, input int cs);
    if (tt == 'h024) return (cwp + NWIN - 1) % NWIN;
    if ((tt & 'h1C0) == 'h080) return (cwp + 2 * NWIN - cs - 2) % NWIN;
    if ((tt & 'h1C0) == 'h0C0) return (cwp + 1) % NWIN;
    return cwp;
  endfunction

  function automatic logic [63:0] m_pc(input int tt, input logic [63:0] tba, input int newtl);
    logic [63:0] r;
    r = tba & ~64'h7FFF;
    if (newtl > 1) r = r | 64'h4000;
    r = r | (64'(tt) << 5);
    return r;
  endfunction

  function automatic logic [42:0] m_tstate(input logic [2:0] gl, input logic [7:0] ccr,
      input logic [7:0] asi, input logic [11:0] p, input bit red, input int cwp);
    logic [11:0] s;
    s = p;
    if (red) s = s | 12'h020;
    s = s & 12'hF3F;
    return (43'(gl) << 40) | (43'(ccr) << 32) | (43'(asi) << 24) | (43'(s) << 8) | 43'(cwp);
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic fire(input int tt);
    trap_type  = 9'(tt);
    trap_valid = 1'b1;
    @(negedge clk);
    trap_valid = 1'b0;
  endtask

  task automatic read_slot(input int idx);
    rd_level = LW'(idx);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [63:0] lvl_pc [MAX_TL + 1];
    logic [11:0] prev_ps;
    logic [63:0] prev_pc;

    do_reset();
    // R1 reset state
    chk("R1 tl", 64'(tl_out), 0);
    chk("R1 err", 64'(error_state), 0);
    chk("R1 taken", 64'(trap_taken), 0);
    chk("R1 pstate", 64'(pstate_out), 0);
    chk("R1 cwp", 64'(cwp_out), 0);
    chk("R1 gl", 64'(gl_out), 0);
    chk("R1 pc", pc_out, 0);
    chk("R1 npc", npc_out, 0);

    // sweep all trap types from level 0
    for (int tt = 0; tt < 512; tt++) begin
      do_reset();
      cwp_in     = CW'(tt % NWIN);
      cansave_in = CW'((tt / NWIN) % NWIN);
      gl_in      = 3'(tt % 8);
      pstate_in  = 12'((tt * 37) ^ 'hA5A);
      ccr_in     = 8'(tt) ^ 8'h3C;
      asi_in     = ~8'(tt);
      pc_in      = 64'h0000_0040_0000_0000 | (64'(tt) << 2);
      npc_in     = pc_in + 64'd4;
      tba_in     = 64'hFEDC_BA98_7654_3210 ^ (64'(tt) << 20);
      fire(tt);
      chk("R2 tl step", 64'(tl_out), 1);
      chk("R2 taken", 64'(trap_taken), 1);
      chk("R10 R9 R8 pstate", 64'(pstate_out), 64'(m_pstate(tt, pstate_in, 1'b0)));
      chk("R11 R12 cwp", 64'(cwp_out), 64'(m_cwp(tt, int'(cwp_in), int'(cansave_in))));
      chk("R6 gl", 64'(gl_out), 64'(3'(gl_in + 3'd1)));
      chk("R13 pc", pc_out, m_pc(tt, tba_in, 1));
      chk("R13 npc", npc_out, m_pc(tt, tba_in, 1) + 64'd4);
      read_slot(1);
      chk("R2 taken pulse", 64'(trap_taken), 0);
      chk("R5 R6 tstate", 64'(rd_tstate),
          64'(m_tstate(gl_in, ccr_in, asi_in, pstate_in, 1'b0, int'(cwp_in))));
      chk("R7 tpc", rd_tpc, pc_in);
      chk("R7 tnpc", rd_tnpc, npc_in);
      chk("R7 tt", 64'(rd_tt), 64'(tt));
    end

    // climb to the ceiling, then one trap beyond
    do_reset();
    prev_ps = '0;
    prev_pc = '0;
    tba_in = 64'h0000_0001_2345_F7FF;
    for (int i = 0; i <= MAX_TL; i++) begin
      pstate_in  = 12'h0C0 | 12'(i);
      cwp_in     = CW'(i);
      cansave_in = CW'(1);
      gl_in      = 3'(i);
      ccr_in     = 8'(8'h10 + i);
      asi_in     = 8'(8'h80 + i);
      pc_in      = 64'h4000_0000 + 64'(i * 16);
      npc_in     = pc_in + 64'd4;
      lvl_pc[i]  = pc_in;
      fire('h041);
      if (i < MAX_TL - 1) begin
        chk("R2 tl", 64'(tl_out), 64'(i + 1));
        chk("R2 no red", 64'(pstate_out), 64'(m_pstate('h041, pstate_in, 1'b0)));
        chk("R13 level pc", pc_out, m_pc('h041, tba_in, i + 1));
      end else if (i == MAX_TL - 1) begin
        chk("R3 tl", 64'(tl_out), 64'(MAX_TL));
        chk("R3 red", 64'(pstate_out), 64'(m_pstate('h041, pstate_in, 1'b1)));
        chk("R13 level pc", pc_out, m_pc('h041, tba_in, MAX_TL));
      end else begin
        chk("R4 tl held", 64'(tl_out), 64'(MAX_TL));
        chk("R4 err", 64'(error_state), 1);
        chk("R4 no taken", 64'(trap_taken), 0);
        chk("R4 pstate held", 64'(pstate_out), 64'(prev_ps));
        chk("R4 pc held", pc_out, prev_pc);
      end
      prev_ps = pstate_out;
      prev_pc = pc_out;
    end
    @(negedge clk);
    chk("R4 err sticky", 64'(error_state), 1);
    for (int i = 1; i <= MAX_TL; i++) begin
      read_slot(i);
      chk("R7 slot tpc", rd_tpc, lvl_pc[i - 1]);
      chk("R7 slot tt", 64'(rd_tt), 64'h041);
    end
    read_slot(MAX_TL);
    chk("R3 R5 saved red", 64'(rd_tstate),
        64'(m_tstate(3'(MAX_TL - 1), 8'(8'h10 + MAX_TL - 1), 8'(8'h80 + MAX_TL - 1),
                     12'h0C0 | 12'(MAX_TL - 1), 1'b1, MAX_TL - 1)));
    do_reset();
    chk("R1 err cleared", 64'(error_state), 0);
    chk("R1 tl cleared", 64'(tl_out), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule